// File: doc/BRIEF.md
# Synthetic Destination Generator for a 4x4 Mesh

This block sits beside one node of a 4x4 on-chip mesh in a traffic test setup. When asked, it produces the destination node ID for the next synthetic packet. Node IDs are 4 bits wide: the row is in the upper two bits and the column in the lower two. A 3-bit mode input selects one of six mappings from source to destination:

- inverting every bit
- reversing the bit order
- swapping row and column
- a fixed diagonal offset that wraps around the mesh
- a pseudo-random pick
- a rotating chain that feeds each result back as the next source

Each accepted request returns the destination together with a one-cycle valid pulse. A flag is raised when the chosen destination is the node's own address, so the caller can drop or count such packets. Packet formatting and injection pacing belong to the logic around this block.

Top module: `traffic_pattern_gen`

## Requirements
- R1: A request (reqStrobe high at a rising edge) with modeSel in 0..5 makes destValid high in the following cycle only. With modeSel 6 or 7, or with no request, destValid is low in the following cycle.
- R2: With modeSel = 0, destAddr is the bitwise inverse of srcAddr. For example, 0000 gives 1111.
- R3: With modeSel = 1, destAddr is srcAddr with its bit order reversed (bit 3 goes to bit 0, bit 0 goes to bit 3). For example, 0001 gives 1000.
- R4: With modeSel = 2, row and column are swapped. The row is in bits [3:2] and the column in bits [1:0], so 0001 (row 0, column 1) gives 0100.
- R5: With modeSel = 3, the destination is the source with 1 added to the row and 1 added to the column, each modulo 4. That is (4-1)/2 hops in each direction, so 0000 gives 0101 and 1111 gives 0000.
- R6: With modeSel = 4, destAddr is the low 4 bits of a 16-bit shift register. The register is reset to 0xACE1 and steps once after each mode-4 request and at no other time. A step is next = {state[14:0], state[15]^state[14]^state[12]^state[3]}. The first two mode-4 requests after reset therefore give 0001 and then 0011, and the third gives 0110.
- R7: With modeSel = 5, the destination is the chain source rotated left by one bit. The first mode-5 request after any cycle in another mode takes chainSeed as its source. Each later mode-5 request takes the previous mode-5 destination. Seed 0111 gives 1110, 1101, 1011 and then 0111.
- R8: selfHit is high exactly when destValid is high and destAddr equals the source used for that request. The source is srcAddr in every mode except 5, where it is the chain source.
- R9: During reset, destAddr is 0000 and destValid and selfHit are low.
- R10: destAddr keeps its value in every cycle that follows a cycle without an accepted request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| reqStrobe | input | 1 | Request for one destination |
| modeSel | input | 3 | Mapping select: 0 invert, 1 reverse, 2 swap, 3 diagonal, 4 random, 5 chain |
| srcAddr | input | 4 | This node's ID (row in [3:2], column in [1:0]) |
| chainSeed | input | 4 | Starting source for the chain mode |
| destAddr | output | 4 | Generated destination ID |
| destValid | output | 1 | One-cycle pulse per accepted request |
| selfHit | output | 1 | Destination equals the source used |

## Verification
Two events can fall in the same cycle:

- a restart of the rotating chain, which happens whenever the mode moves into 5;
- a request, which advances the chain.

The bench provokes this by raising reqStrobe in the very cycle modeSel changes to 5. It then checks that the result is the rotation of chainSeed and not of a stale chain value. A random phase flips mode and strobe independently on every cycle, so restarts, held chains and random-register steps mix with one another. A behavioural model judges every cycle's outputs.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

  typedef enum logic [2:0] {
    MODE_INV   = 3'd0,
    MODE_REV   = 3'd1,
    MODE_TRANS = 3'd2,
    MODE_TORN  = 3'd3,
    MODE_UNI   = 3'd4,
    MODE_SHUF  = 3'd5
  } mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic  capture;       // accepted request this cycle
    mode_e pick;          // mapping to apply
    logic  lfsrStep;      // advance random register
    logic  chainAdvance;  // store result as next chain source
    logic  chainClear;    // chain restarts from seed
  } ctrl_s;

endpackage

// File: rtl/tpg_lfsr.sv
module tpg_lfsr #(
  parameter int          WIDTH = 16,
  parameter int          OUT_W = 4,
  parameter logic [WIDTH-1:0] SEED = 16'hACE1,
  parameter logic [WIDTH-1:0] TAPS = 16'hD008
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             step,
  output logic [OUT_W-1:0] draw
);

  logic [WIDTH-1:0] state;
  logic             feedBit;

  assign feedBit = ^(state & TAPS);
  assign draw    = state[OUT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= SEED;
    end else if (step) begin
      state <= {state[WIDTH-2:0], feedBit};
    end
  end

endmodule

// File: rtl/tpg_ctrl.sv
module tpg_ctrl
  import tpg_pkg::*;
(
  input  logic       reqStrobe,
  input  logic [2:0] modeSel,
  output ctrl_s      ctl
);

  logic  modeKnown;
  mode_e modeCur;

  assign modeCur   = mode_e'(modeSel);
  assign modeKnown = (modeSel <= 3'(MODE_SHUF));

  always_comb begin
    ctl              = '0;
    ctl.pick         = modeCur;
    ctl.capture      = reqStrobe && modeKnown;
    ctl.lfsrStep     = ctl.capture && (modeCur == MODE_UNI);
    ctl.chainAdvance = ctl.capture && (modeCur == MODE_SHUF);
    ctl.chainClear   = (modeCur != MODE_SHUF);
  end

endmodule

// File: rtl/tpg_datapath.sv
module tpg_datapath
  import tpg_pkg::*;
#(
  parameter int               ROW_W     = 2,
  parameter int               COL_W     = 2,
  parameter int               LFSR_W    = 16,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hD008,
  localparam int              ADDR_W    = ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_s             ctl,
  input  logic [ADDR_W-1:0] srcAddr,
  input  logic [ADDR_W-1:0] chainSeed,
  output logic [ADDR_W-1:0] destAddr,
  output logic              destValid,
  output logic              selfHit
);

  localparam int ROW_RADIX = 1 << ROW_W;
  localparam int COL_RADIX = 1 << COL_W;
  localparam logic [ROW_W-1:0] ROW_HOP = ROW_W'((ROW_RADIX - 1) / 2);
  localparam logic [COL_W-1:0] COL_HOP = COL_W'((COL_RADIX - 1) / 2);

  logic [ADDR_W-1:0] chainAddr;
  logic              chainLive;
  logic [ADDR_W-1:0] effSrc;
  logic [ADDR_W-1:0] revAddr;
  logic [ADDR_W-1:0] randAddr;
  logic [ADDR_W-1:0] nextDest;
  logic [ROW_W-1:0]  effRow;
  logic [COL_W-1:0]  effCol;

  tpg_lfsr #(
    .WIDTH(LFSR_W),
    .OUT_W(ADDR_W),
    .SEED (LFSR_SEED),
    .TAPS (LFSR_TAPS)
  ) u_lfsr (
    .clk (clk),
    .rstN(rstN),
    .step(ctl.lfsrStep),
    .draw(randAddr)
  );

  // source for this request
  assign effSrc = (ctl.pick == MODE_SHUF) ? (chainLive ? chainAddr : chainSeed) : srcAddr;
  assign effRow = effSrc[ADDR_W-1:COL_W];
  assign effCol = effSrc[COL_W-1:0];

  for (genvar i = 0; i < ADDR_W; i++) begin : g_rev
    assign revAddr[i] = effSrc[ADDR_W-1-i];
  end

  always_comb begin
    case (ctl.pick)
      MODE_INV:   nextDest = ~effSrc;
      MODE_REV:   nextDest = revAddr;
      MODE_TRANS: nextDest = {effCol, effRow};
      MODE_TORN:  nextDest = {effRow + ROW_HOP, effCol + COL_HOP};
      MODE_UNI:   nextDest = randAddr;
      MODE_SHUF:  nextDest = {effSrc[ADDR_W-2:0], effSrc[ADDR_W-1]};
      default:    nextDest = destAddr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chainAddr <= '0;
      chainLive <= 1'b0;
    end else if (ctl.chainAdvance) begin
      chainAddr <= nextDest;
      chainLive <= 1'b1;
    end else if (ctl.chainClear) begin
      chainLive <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      destAddr  <= '0;
      destValid <= 1'b0;
      selfHit   <= 1'b0;
    end else begin
      destValid <= ctl.capture;
      selfHit   <= ctl.capture && (nextDest == effSrc);
      if (ctl.capture) begin
        destAddr <= nextDest;
      end
    end
  end

endmodule

// File: rtl/traffic_pattern_gen.sv
module traffic_pattern_gen
  import tpg_pkg::*;
#(
  parameter int               ROW_W     = 2,
  parameter int               COL_W     = 2,
  parameter int               LFSR_W    = 16,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hD008,
  localparam int              ADDR_W    = ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqStrobe,
  input  logic [2:0]        modeSel,
  input  logic [ADDR_W-1:0] srcAddr,
  input  logic [ADDR_W-1:0] chainSeed,
  output logic [ADDR_W-1:0] destAddr,
  output logic              destValid,
  output logic              selfHit
);

  ctrl_s ctl;

  tpg_ctrl u_ctrl (
    .reqStrobe(reqStrobe),
    .modeSel  (modeSel),
    .ctl      (ctl)
  );

  tpg_datapath #(
    .ROW_W    (ROW_W),
    .COL_W    (COL_W),
    .LFSR_W   (LFSR_W),
    .LFSR_SEED(LFSR_SEED),
    .LFSR_TAPS(LFSR_TAPS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .srcAddr  (srcAddr),
    .chainSeed(chainSeed),
    .destAddr (destAddr),
    .destValid(destValid),
    .selfHit  (selfHit)
  );

endmodule

// File: rtl/tpg_checker.sv
module tpg_checker
  import tpg_pkg::*;
#(
  parameter int  ROW_W  = 2,
  parameter int  COL_W  = 2,
  localparam int ADDR_W = ROW_W + COL_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqStrobe,
  input logic [2:0]        modeSel,
  input logic [ADDR_W-1:0] srcAddr,
  input logic [ADDR_W-1:0] destAddr,
  input logic              destValid,
  input logic              selfHit
);

  logic accepted;
  assign accepted = reqStrobe && (modeSel <= 3'(MODE_SHUF));

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rstN)
    accepted |=> destValid);

  assert_quiet_without_req_R1: assert property (@(posedge clk) disable iff (!rstN)
    !accepted |=> !destValid);

  assert_dest_holds_R10: assert property (@(posedge clk) disable iff (!rstN)
    !accepted |=> $stable(destAddr));

  assert_invert_R2: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && modeSel == 3'(MODE_INV)) |=> destAddr == ~$past(srcAddr));

  assert_swap_R4: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && modeSel == 3'(MODE_TRANS)) |=>
      destAddr == {$past(srcAddr[COL_W-1:0]), $past(srcAddr[ADDR_W-1:COL_W])});

  assert_self_needs_valid_R8: assert property (@(posedge clk) disable iff (!rstN)
    selfHit |-> destValid);

  assert_invert_never_self_R8: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && modeSel == 3'(MODE_INV)) |=> !selfHit);

endmodule

bind traffic_pattern_gen tpg_checker #(.ROW_W(ROW_W), .COL_W(COL_W)) u_checker (
  .clk      (clk),
  .rstN     (rstN),
  .reqStrobe(reqStrobe),
  .modeSel  (modeSel),
  .srcAddr  (srcAddr),
  .destAddr (destAddr),
  .destValid(destValid),
  .selfHit  (selfHit)
);

// File: tb/traffic_pattern_gen_test.sv
module traffic_pattern_gen_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqStrobe = 1'b0;
  logic [2:0] modeSel = 3'd0;
  logic [3:0] srcAddr = 4'd0;
  logic [3:0] chainSeed = 4'd0;
  logic [3:0] destAddr;
  logic       destValid;
  logic       selfHit;

  int total = 0;
  int bad = 0;
  bit modelOn = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  traffic_pattern_gen uut (
    .clk(clk), .rstN(rstN), .reqStrobe(reqStrobe), .modeSel(modeSel),
    .srcAddr(srcAddr), .chainSeed(chainSeed),
    .destAddr(destAddr), .destValid(destValid), .selfHit(selfHit)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string tagOf(int m, bit cap);
    if (!cap) return "R10";
    case (m)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5: return "R7";
      default: return "R1";
    endcase
  endfunction

  // behavioural reference model
  logic [15:0] mRand;
  logic [3:0]  mDest, mChain, mSrc, mNext;
  logic        mValid, mSelf, mLive, mCap;
  int          mMode;

  always @(posedge clk) begin
    if (!rstN) begin
      mRand = 16'hACE1; mDest = 4'd0; mValid = 1'b0; mSelf = 1'b0;
      mLive = 1'b0; mChain = 4'd0; mMode = 0; mCap = 1'b0;
    end else begin
      mMode = int'(modeSel);
      mCap  = reqStrobe && (mMode < 6);
      mSrc  = (mMode == 5) ? (mLive ? mChain : chainSeed) : srcAddr;
      case (mMode)
        0: mNext = ~mSrc;
        1: mNext = {mSrc[0], mSrc[1], mSrc[2], mSrc[3]};
        2: mNext = {mSrc[1:0], mSrc[3:2]};
        3: mNext = {2'(mSrc[3:2] + 2'd1), 2'(mSrc[1:0] + 2'd1)};
        4: mNext = mRand[3:0];
        5: mNext = {mSrc[2:0], mSrc[3]};
        default: mNext = mDest;
      endcase
      if (mMode == 5) begin
        if (mCap) begin mChain = mNext; mLive = 1'b1; end
      end else begin
        mLive = 1'b0;
      end
      if (mCap && mMode == 4)
        mRand = {mRand[14:0], mRand[15] ^ mRand[14] ^ mRand[12] ^ mRand[3]};
      mValid = mCap;
      if (mCap) mDest = mNext;
      mSelf = mCap && (mNext == mSrc);
    end
  end

  // every-cycle comparison
  always @(negedge clk) begin
    if (modelOn) begin
      chk("R1", int'(destValid), int'(mValid));
      chk(tagOf(mMode, mCap), int'(destAddr), int'(mDest));
      chk("R8", int'(selfHit), int'(mSelf));
    end
  end

  task automatic fire(int m, int s, int seed, int expD, int expS, string tag);
    @(negedge clk);
    modeSel = 3'(m); srcAddr = 4'(s); chainSeed = 4'(seed); reqStrobe = 1'b1;
    @(negedge clk);
    reqStrobe = 1'b0;
    chk(tag, int'(destAddr), expD);
    chk("R8", int'(selfHit), expS);
    chk("R1", int'(destValid), 1);
  endtask

  task automatic quiet(int m, bit strobe, int holdD);
    @(negedge clk);
    modeSel = 3'(m); reqStrobe = strobe;
    @(negedge clk);
    reqStrobe = 1'b0;
    chk("R1", int'(destValid), 0);
    chk("R10", int'(destAddr), holdD);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9", int'(destAddr), 0);
    chk("R9", int'(destValid), 0);
    chk("R9", int'(selfHit), 0);
    rstN = 1'b1;
    modelOn = 1'b1;

    // random register: 0xACE1 -> low nibble 1, then 3
    fire(4, 0, 0, 4'b0001, 0, "R6");
    fire(4, 0, 0, 4'b0011, 0, "R6");
    quiet(4, 1'b0, 4'b0011);
    fire(0, 4'b0000, 0, 4'b1111, 0, "R2");
    fire(0, 4'b1010, 0, 4'b0101, 0, "R2");
    fire(1, 4'b0001, 0, 4'b1000, 0, "R3");
    fire(1, 4'b1101, 0, 4'b1011, 0, "R3");
    fire(1, 4'b1001, 0, 4'b1001, 1, "R3");
    fire(2, 4'b0001, 0, 4'b0100, 0, "R4");
    fire(2, 4'b0101, 0, 4'b0101, 1, "R4");
    fire(3, 4'b0000, 0, 4'b0101, 0, "R5");
    fire(3, 4'b1111, 0, 4'b0000, 0, "R5");
    fire(3, 4'b0110, 0, 4'b1011, 0, "R5");
    // register did not step outside mode 4: third value 0x6
    fire(4, 0, 0, 4'b0110, 0, "R6");
    // reserved codes
    quiet(6, 1'b1, 4'b0110);
    quiet(7, 1'b1, 4'b0110);
    // chain from seed 0111, started in the same cycle mode becomes 5
    fire(5, 4'b0000, 4'b0111, 4'b1110, 0, "R7");
    fire(5, 4'b0000, 4'b0000, 4'b1101, 0, "R7");
    fire(5, 4'b0000, 4'b0000, 4'b1011, 0, "R7");
    fire(5, 4'b0000, 4'b0000, 4'b0111, 0, "R7");
    quiet(5, 1'b0, 4'b0111);
    fire(5, 4'b0000, 4'b0000, 4'b1110, 0, "R7");
    // leave mode 5, return: restarts from seed
    quiet(0, 1'b0, 4'b1110);
    fire(5, 4'b1111, 4'b0000, 4'b0000, 1, "R7");
    fire(5, 4'b0000, 4'b1001, 4'b0000, 1, "R7");

    // mixed random phase
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      modeSel   = 3'($urandom_range(0, 7));
      reqStrobe = 1'($urandom_range(0, 1));
      srcAddr   = 4'($urandom);
      chainSeed = 4'($urandom);
    end
    // sustained chain bursts
    for (int j = 0; j < 20; j++) begin
      @(negedge clk);
      modeSel = 3'd0; reqStrobe = 1'b0; chainSeed = 4'($urandom);
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        modeSel = 3'd5; reqStrobe = 1'($urandom_range(0, 3) != 0);
      end
    end
    @(negedge clk);
    reqStrobe = 1'b0;
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule